// File: doc/BRIEF.md
# External Interrupt Vectoring Unit

This block watches one external interrupt pin, turns a qualifying edge on it into a latched request flag, and steers a small instruction sequencer to a fixed interrupt vector. The sequencer counts a four-phase instruction cycle (Q1, Q2, Q3, Q4), one phase per clock. It stands in for the program counter side of a small core. It advances the fetch address once per executed instruction. It supports instructions that take two cycles. It can park the core in sleep and bring it back when the pin fires.

The flag is looked at only once per instruction cycle, at Q1. When the flag, the source enable and the global enable are all set at that sample, the running instruction finishes. Two dummy cycles follow, during which the return address is held and nothing executes. Then the vector instruction runs. From sleep, the source enable alone is enough to wake the core, and the global enable decides whether it then vectors or simply carries on.

Top module: `ext_irq_vector`

## Requirements
- R1: With `rise_sel` = 1, a 0-to-1 change of `int_pin` sets `int_flag` on the third clock edge after the pin changes. A 1-to-0 change does not set it, and neither does toggling `rise_sel` while the pin is still.
- R2: With `rise_sel` = 0, a 1-to-0 change of `int_pin` sets `int_flag` with the same timing as R1. A 0-to-1 change does not set it.
- R3: `int_flag` stays set until `flag_clr` is high at a clock edge, which clears it. If a valid edge is detected at the same clock edge as `flag_clr`, the flag stays set.
- R4: The sequencer enters the interrupt only if `int_flag`, `src_en` and `glb_en` are all 1 at a Q1 sample. If any of the three is 0, no vector is taken.
- R5: `phase` steps 0,1,2,3 (Q1..Q4) each clock. If the flag is set when instruction cycle c is sampled at Q1, the vector instruction starts at cycle c+3. `vec_taken` is high for exactly the Q1 clock of that cycle.
- R6: Cycles c+1 and c+2 are dummy cycles. In them, `exec_stb` stays low and `fetch_pc` holds the return address, which is the address after the interrupted instruction. `ret_pc` presents that return address.
- R7: In the vector cycle, `fetch_pc` equals `VEC_ADDR` (default 4) and `vec_taken` drops after one clock.
- R8: When every instruction takes two cycles (`long_op` = 1), the vector still starts three cycles after the sampling cycle, whichever half of the instruction was sampled.
- R9: A `sleep_req` sampled at Q1 of a single-cycle instruction puts the core to sleep after that instruction. While asleep, `fetch_pc` is frozen and `exec_stb` stays low. A set flag with `src_en` = 0 does not wake it.
- R10: While asleep with `src_en` = 1, a set flag raises `wake`. If `glb_en` was 1 at the waking Q1 sample, the core vectors three cycles later with `ret_pc` equal to the sleep address. If not, it resumes execution at `fetch_pc` in the next cycle.
- R11: After a vector is taken, the global enable is treated as cleared until `glb_en` is seen low. A flag left set does not cause a second entry until then.
- R12: In reset, `fetch_pc` is 0, `phase` is 0 and `int_flag`, `vec_taken` and `exec_stb` are 0. `exec_stb` pulses in Q4 of each executing cycle, and the address advances by one per instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock; one clock per Q phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_pin | input | 1 | Asynchronous external interrupt pin |
| rise_sel | input | 1 | 1: rising edge is valid, 0: falling edge is valid |
| flag_clr | input | 1 | Software strobe that clears the flag |
| src_en | input | 1 | Enable for this interrupt source |
| glb_en | input | 1 | Global interrupt enable |
| sleep_req | input | 1 | Current instruction is a sleep request |
| long_op | input | 1 | Current instruction takes two cycles |
| int_flag | output | 1 | Latched interrupt flag |
| wake | output | 1 | Asleep and a wake condition is present |
| vec_taken | output | 1 | One-clock pulse at Q1 of the vector cycle; request to clear the global enable |
| fetch_pc | output | PC_W | Address of the instruction in the current cycle |
| ret_pc | output | PC_W | Return address for the stack |
| exec_stb | output | 1 | Instruction completed (Q4 of an executing cycle) |
| phase | output | 2 | Current Q phase, 0 = Q1 .. 3 = Q4 |

## Verification
The assertions assume that the control inputs stay steady between the Q1 sample that uses them and the end of that instruction cycle. They also assume that the pin holds each level for at least two clocks, so the synchronizer can see every change. The stimulus changes controls only at the falling clock edge. It holds each pin level for many cycles, and it keeps the pin stable through reset, so the synchronizer is settled before the first edge is judged. `sleep_req` is raised only together with single-cycle instructions, which is the only case the sequencer defines.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_t;

  typedef enum logic [2:0] {
    SQ_RUN   = 3'd0,
    SQ_LONG2 = 3'd1,
    SQ_DUM1  = 3'd2,
    SQ_DUM2  = 3'd3,
    SQ_SLEEP = 3'd4
  } seq_t;

  // Qualifying edge for the selected polarity.
  function automatic logic edge_valid(input logic rise, input logic now_v, input logic was_v);
    return rise ? (now_v & ~was_v) : (~now_v & was_v);
  endfunction

  function automatic phase_t phase_next(input phase_t p);
    return phase_t'(p + 2'd1);
  endfunction

endpackage

// File: rtl/qphase_gen.sv
module qphase_gen
  import extirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase,
  output logic   q1_now,
  output logic   q4_now
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_Q1;
    else        phase <= phase_next(phase);
  end

  assign q1_now = (phase == PH_Q1);
  assign q4_now = (phase == PH_Q4);

endmodule

// File: rtl/pin_edge_sync.sv
module pin_edge_sync
  import extirq_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_hit
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  // Plain shift register; the bench holds the pin steady through reset.
  always_ff @(posedge clk) begin
    chain[0] <= pin;
    for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    prev <= chain[LAST];
  end

  assign edge_hit = edge_valid(rise_sel, chain[LAST], prev);

endmodule

// File: rtl/irq_flag_latch.sv
module irq_flag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr,
  output logic flag
);

  // A set at the same edge as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end

endmodule

// File: rtl/vec_sequencer.sv
module vec_sequencer
  import extirq_pkg::*;
#(
  parameter int PC_W       = 11,
  parameter int VEC_ADDR   = 4,
  parameter int RESET_ADDR = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            q1_now,
  input  logic            q4_now,
  input  logic            flag,
  input  logic            src_en,
  input  logic            glb_en,
  input  logic            sleep_req,
  input  logic            long_op,
  output logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] ret_pc,
  output logic            exec_stb,
  output logic            vec_taken,
  output logic            wake,
  output logic            in_dummy,
  output logic            asleep,
  output logic            take_req
);

  localparam logic [PC_W-1:0] VEC_PC = PC_W'(VEC_ADDR);
  localparam logic [PC_W-1:0] RST_PC = PC_W'(RESET_ADDR);

  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  seq_t st;
  logic glb_mask, glb_eff, wake_req;
  logic s_take, s_wake, s_gie, s_sleep, s_long, carry;

  assign glb_eff  = glb_en & ~glb_mask;
  assign take_req = flag & src_en & glb_eff;
  assign wake_req = flag & src_en;

  // Q1 sample of everything the cycle's decision uses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_take  <= 1'b0;
      s_wake  <= 1'b0;
      s_gie   <= 1'b0;
      s_sleep <= 1'b0;
      s_long  <= 1'b0;
    end else if (q1_now) begin
      s_take  <= take_req;
      s_wake  <= wake_req;
      s_gie   <= glb_eff;
      s_sleep <= sleep_req;
      s_long  <= long_op;
    end
  end

  // Global enable masked from vector entry until software drops it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          glb_mask <= 1'b0;
    else if (q4_now && st == SQ_DUM2)    glb_mask <= 1'b1;
    else if (!glb_en)                    glb_mask <= 1'b0;
  end

  // Cycle-end decision at the Q4 edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_RUN;
      fetch_pc  <= RST_PC;
      ret_pc    <= RST_PC;
      carry     <= 1'b0;
      vec_taken <= 1'b0;
    end else begin
      vec_taken <= q4_now && (st == SQ_DUM2);
      if (q4_now) begin
        case (st)
          SQ_RUN: begin
            if (s_long) begin
              st    <= SQ_LONG2;
              carry <= s_take;
            end else if (s_take) begin
              fetch_pc <= pc_step(fetch_pc);
              ret_pc   <= pc_step(fetch_pc);
              st       <= SQ_DUM1;
            end else if (s_sleep) begin
              fetch_pc <= pc_step(fetch_pc);
              st       <= SQ_SLEEP;
            end else begin
              fetch_pc <= pc_step(fetch_pc);
            end
          end
          SQ_LONG2: begin
            fetch_pc <= pc_step(fetch_pc);
            carry    <= 1'b0;
            if (carry) begin
              ret_pc <= pc_step(fetch_pc);
              st     <= SQ_DUM2;
            end else if (s_take) begin
              ret_pc <= pc_step(fetch_pc);
              st     <= SQ_DUM1;
            end else begin
              st <= SQ_RUN;
            end
          end
          SQ_DUM1: st <= SQ_DUM2;
          SQ_DUM2: begin
            fetch_pc <= VEC_PC;
            st       <= SQ_RUN;
          end
          SQ_SLEEP: begin
            if (s_wake) begin
              if (s_gie) begin
                ret_pc <= fetch_pc;
                st     <= SQ_DUM1;
              end else begin
                st <= SQ_RUN;
              end
            end
          end
          default: st <= SQ_RUN;
        endcase
      end
    end
  end

  assign in_dummy = (st == SQ_DUM1) || (st == SQ_DUM2);
  assign asleep   = (st == SQ_SLEEP);
  assign wake     = asleep & wake_req;
  assign exec_stb = q4_now & ((st == SQ_RUN) || (st == SQ_LONG2));

endmodule

// File: rtl/ext_irq_vector.sv
module ext_irq_vector
  import extirq_pkg::*;
#(
  parameter int PC_W        = 11,
  parameter int VEC_ADDR    = 4,
  parameter int RESET_ADDR  = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            int_pin,
  input  logic            rise_sel,
  input  logic            flag_clr,
  input  logic            src_en,
  input  logic            glb_en,
  input  logic            sleep_req,
  input  logic            long_op,
  output logic            int_flag,
  output logic            wake,
  output logic            vec_taken,
  output logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] ret_pc,
  output logic            exec_stb,
  output logic [1:0]      phase
);

  phase_t ph;
  logic   q1_now, q4_now;
  logic   edge_hit, in_dummy, asleep, take_req;

  qphase_gen u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (ph),
    .q1_now (q1_now),
    .q4_now (q4_now)
  );

  pin_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .pin      (int_pin),
    .rise_sel (rise_sel),
    .edge_hit (edge_hit)
  );

  irq_flag_latch u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (edge_hit),
    .clr    (flag_clr),
    .flag   (int_flag)
  );

  vec_sequencer #(
    .PC_W       (PC_W),
    .VEC_ADDR   (VEC_ADDR),
    .RESET_ADDR (RESET_ADDR)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .q1_now    (q1_now),
    .q4_now    (q4_now),
    .flag      (int_flag),
    .src_en    (src_en),
    .glb_en    (glb_en),
    .sleep_req (sleep_req),
    .long_op   (long_op),
    .fetch_pc  (fetch_pc),
    .ret_pc    (ret_pc),
    .exec_stb  (exec_stb),
    .vec_taken (vec_taken),
    .wake      (wake),
    .in_dummy  (in_dummy),
    .asleep    (asleep),
    .take_req  (take_req)
  );

  assign phase = ph;

endmodule

// File: rtl/ext_irq_vector_chk.sv
module ext_irq_vector_chk #(
  parameter int PC_W     = 11,
  parameter int VEC_ADDR = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flag_clr,
  input logic            glb_en,
  input logic            int_flag,
  input logic            vec_taken,
  input logic [PC_W-1:0] fetch_pc,
  input logic            exec_stb,
  input logic [1:0]      phase,
  input logic            edge_hit,
  input logic            in_dummy,
  input logic            asleep
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b1;
    else if (vec_taken) armed <= 1'b0;
    else if (!glb_en)  armed <= 1'b1;
  end

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> $past(edge_hit)); // R1
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    int_flag && !flag_clr |=> int_flag); // R3
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> phase == $past(phase) + 2'd1); // R5
  AST_VEC_AT_Q1: assert property (@(posedge clk) disable iff (!rst_n)
    vec_taken |-> phase == 2'd0); // R5
  AST_DUMMY_NOEXEC: assert property (@(posedge clk) disable iff (!rst_n)
    in_dummy |-> !exec_stb); // R6
  AST_DUMMY_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_dummy && $past(in_dummy) |-> $stable(fetch_pc)); // R6
  AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    vec_taken |-> fetch_pc == PC_W'(VEC_ADDR)); // R7
  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_taken |=> !vec_taken); // R7
  AST_SLEEP_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && $past(asleep) |-> $stable(fetch_pc)); // R9
  AST_SLEEP_NOEXEC: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !exec_stb); // R9
  AST_NO_RETAKE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_taken |-> armed); // R11
  AST_EXEC_Q4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> phase == 2'd3); // R12

endmodule

bind ext_irq_vector ext_irq_vector_chk #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flag_clr  (flag_clr),
  .glb_en    (glb_en),
  .int_flag  (int_flag),
  .vec_taken (vec_taken),
  .fetch_pc  (fetch_pc),
  .exec_stb  (exec_stb),
  .phase     (phase),
  .edge_hit  (edge_hit),
  .in_dummy  (in_dummy),
  .asleep    (asleep)
);

// File: tb/tb_ext_irq_vector.sv
`timescale 1ns/1ps
module tb_ext_irq_vector;

  localparam int PC_W = 11;
  localparam int VEC  = 4;

  typedef struct packed {
    logic       rise;
    logic       pin_to;
    logic [1:0] off;
    logic       ie;
    logic       gie;
    logic       lng;
    logic       expv;
  } case_t;

  // rise, pin_to, inject offset, src_en, glb_en, long_op, vector expected
  localparam case_t CASES [10] = '{
    '{1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_pin = 1'b0, rise_sel = 1'b1, flag_clr = 1'b0;
  logic src_en = 1'b0, glb_en = 1'b0, sleep_req = 1'b0, long_op = 1'b0;
  logic int_flag, wake, vec_taken, exec_stb;
  logic [PC_W-1:0] fetch_pc, ret_pc;
  logic [1:0] phase;

  int ecount = 0;
  int execs = 0;
  int vecs = 0;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
    if (exec_stb)  execs <= execs + 1;
    if (vec_taken) vecs  <= vecs + 1;
  end

  ext_irq_vector #(.PC_W(PC_W), .VEC_ADDR(VEC)) dut (
    .clk(clk), .rst_n(rst_n), .int_pin(int_pin), .rise_sel(rise_sel),
    .flag_clr(flag_clr), .src_en(src_en), .glb_en(glb_en),
    .sleep_req(sleep_req), .long_op(long_op), .int_flag(int_flag),
    .wake(wake), .vec_taken(vec_taken), .fetch_pc(fetch_pc),
    .ret_pc(ret_pc), .exec_stb(exec_stb), .phase(phase)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic pin, input logic rs, input logic ie,
                          input logic gie, input logic lng, input logic slp);
    @(negedge clk);
    rst_n = 1'b0; int_pin = pin; rise_sel = rs; src_en = ie; glb_en = gie;
    long_op = lng; sleep_req = slp; flag_clr = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic goto(input int n);
    while (ecount < n) @(negedge clk);
  endtask

  // First Q1 sampling edge at or after edge k (edge k samples when (k-1)%4==0).
  function automatic int first_q1(input int k);
    int r = k;
    while ((r - 1) % 4 != 0) r++;
    return r;
  endfunction

  task automatic run_case(input case_t c);
    int k0, ks, cyc, expret, vec_at;
    bit valid;
    do_reset(~c.pin_to, c.rise, c.ie, c.gie, c.lng, 1'b0);
    k0 = 21 + int'(c.off);
    ks = first_q1(k0 + 3);
    cyc = (ks - 1) / 4;
    expret = c.lng ? cyc / 2 + 1 : cyc + 1;
    valid = (c.rise == c.pin_to);
    vec_at = -1;
    goto(k0 - 1);
    int_pin = c.pin_to;
    while (ecount < k0 + 70) begin
      @(negedge clk);
      if (ecount == k0 + 1) chk(int_flag == 1'b0, c.rise ? "R1" : "R2", int_flag, 0);
      if (ecount == k0 + 2) chk(int_flag == valid, c.rise ? "R1" : "R2", int_flag, valid);
      if (c.expv && !c.lng && ecount == ks + 5)
        chk(fetch_pc == PC_W'(expret), "R6", int'(fetch_pc), expret);
      if (c.expv && !c.lng && ecount == ks + 6) chk(exec_stb == 1'b0, "R6", exec_stb, 0);
      if (vec_taken && vec_at < 0) begin
        vec_at = ecount;
        chk(fetch_pc == PC_W'(VEC), "R7", int'(fetch_pc), VEC);
        chk(ret_pc == PC_W'(expret), "R6", int'(ret_pc), expret);
      end
      if (c.expv && ecount == ks + 12) chk(vec_taken == 1'b0, "R7", vec_taken, 0);
    end
    if (c.expv) chk(vec_at == ks + 11, c.lng ? "R8" : "R5", vec_at, ks + 11);
    else        chk(vec_at < 0, "R4", vec_at, -1);
  endtask

  initial begin
    int e0, v0;

    // Reset state (R12)
    @(negedge clk);
    @(negedge clk);
    chk(fetch_pc == '0, "R12", int'(fetch_pc), 0);
    chk(phase == 2'd0, "R12", phase, 0);
    chk(int_flag == 1'b0 && vec_taken == 1'b0 && exec_stb == 1'b0, "R12",
        {int_flag, vec_taken, exec_stb}, 0);

    // Vector walk
    for (int i = 0; i < 10; i++) run_case(CASES[i]);

    // Instruction progression (R12)
    do_reset(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    goto(3); chk(exec_stb == 1'b1, "R12", exec_stb, 1);
    goto(4); chk(exec_stb == 1'b0, "R12", exec_stb, 0);
    goto(9); chk(fetch_pc == PC_W'(2), "R12", int'(fetch_pc), 2);

    // Flag hold, clear, clear against a new edge (R3), select toggle (R1)
    do_reset(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    goto(10); int_pin = 1'b1;
    goto(20); chk(int_flag == 1'b1, "R3", int_flag, 1);
    int_pin = 1'b0;
    goto(30); chk(int_flag == 1'b1, "R1", int_flag, 1);
    goto(40); int_pin = 1'b1;
    goto(42); flag_clr = 1'b1;
    goto(43); flag_clr = 1'b0;
    chk(int_flag == 1'b1, "R3", int_flag, 1);
    goto(50); flag_clr = 1'b1;
    goto(51); flag_clr = 1'b0;
    chk(int_flag == 1'b0, "R3", int_flag, 0);
    goto(60); rise_sel = 1'b0;
    goto(70); rise_sel = 1'b1;
    goto(80); chk(int_flag == 1'b0, "R1", int_flag, 0);

    // Global enable masking after entry (R11)
    do_reset(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    v0 = vecs;
    goto(20); int_pin = 1'b1;
    goto(110); chk(vecs - v0 == 1, "R11", vecs - v0, 1);
    goto(120); glb_en = 1'b0;
    goto(128); glb_en = 1'b1;
    goto(150); chk(vecs - v0 == 2, "R11", vecs - v0, 2);

    // Sleep, wake without global enable (R9, R10)
    do_reset(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    goto(2); sleep_req = 1'b0;
    goto(8); e0 = execs;
    goto(20); chk(fetch_pc == PC_W'(1), "R9", int'(fetch_pc), 1);
    goto(40);
    chk(fetch_pc == PC_W'(1), "R9", int'(fetch_pc), 1);
    chk(wake == 1'b0, "R9", wake, 0);
    int_pin = 1'b1;
    goto(43); chk(wake == 1'b1, "R10", wake, 1);
    goto(48); chk(execs == e0, "R9", execs - e0, 0);
    goto(49); chk(wake == 1'b0, "R10", wake, 0);
    goto(53); chk(fetch_pc == PC_W'(2), "R10", int'(fetch_pc), 2);
    chk(vecs == v0 + 2, "R10", vecs - v0, 2);

    // Sleep with source disabled: no wake (R9)
    do_reset(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    goto(2); sleep_req = 1'b0;
    goto(40); int_pin = 1'b1;
    goto(60);
    chk(int_flag == 1'b1, "R9", int_flag, 1);
    chk(wake == 1'b0, "R9", wake, 0);
    chk(fetch_pc == PC_W'(1), "R9", int'(fetch_pc), 1);

    // Sleep, wake with global enable: vectors (R10)
    do_reset(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    goto(2); sleep_req = 1'b0;
    goto(40); int_pin = 1'b1;
    goto(55); chk(vec_taken == 1'b0, "R10", vec_taken, 0);
    goto(56);
    chk(vec_taken == 1'b1, "R10", vec_taken, 1);
    chk(ret_pc == PC_W'(1), "R10", int'(ret_pc), 1);
    chk(fetch_pc == PC_W'(VEC), "R10", int'(fetch_pc), VEC);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule